// File: doc/BRIEF.md
# SATA Link Control Register

This block is the software-facing control word for one serial ATA port. It sits on a plain register bus with an address, write data, per-byte write enables, a write strobe and a combinational read-data return. It keeps two live fields: a speed cap and a detection/initialization command. A third field, for interface power management, is present in the layout but is not implemented. Writes to it are dropped, and it always reads back as zero.

The detection field does not act on the value it holds. It acts on the change that a software write makes to it. Two changes count as a launch: idle to hard-reset-request, and offline to idle. A launch loads a cycle counter, and `init_active` stays high while that counter runs. This counter takes the place of the real initialization handshake with the PHY. A new launch while the counter is running reloads it from the full length. The command value for offline drives `phy_offline` for as long as the field holds it.

The reset value of the detection field depends on a mode strap. In one mode the field resets to idle and an initialization runs straight out of reset. In the other mode the field resets to offline and the PHY stays parked.

Top module: `sata_link_ctrl`

## Requirements
- R1: Reads at `REG_ADDR` return zero in bits 31:12. Reads at any other address return all zeros. Writes to any other address change nothing.
- R2: The power-management field (bits 11:8) ignores every write and always reads 0000.
- R3: The speed field (bits 7:4) stores whatever is written. `gen1_limit` is high exactly when the field holds 0001. A reserved speed code is stored but leaves `gen1_limit` low.
- R4: Reset depends on `strap_autoinit`. With the strap high, the detection field (bits 3:0) resets to 0000 and `init_active` is high from reset release for exactly `INIT_CYCLES` sampled cycles. With the strap low, the detection field resets to 0100, `phy_offline` is high and `init_active` stays low.
- R5: `phy_offline` is high exactly while the detection field holds 0100.
- R6: A write that changes the detection field from 0100 to 0000 starts an initialization. `init_active` is high from the cycle after the write edge for `INIT_CYCLES` cycles.
- R7: A write that changes the detection field from 0000 to 0001 starts an initialization with the same timing. Writing 0001 while the field already holds 0001 does not start one.
- R8: Writing 0000 on the access right after 0001 does not shorten the initialization already running.
- R9: A new 0000-to-0001 change during a running initialization restarts it. `init_active` then stays high for a full `INIT_CYCLES` cycles counted from that write.
- R10: Any other change of the detection field starts nothing. This includes changes into or out of reserved codes, 0100 to 0001, and 0001 to 0100. Reserved codes are still stored and read back.
- R11: Byte lane 0 (`be[0]`) gates both the detection and the speed fields. A write with `be[0]` low updates neither field and cannot start an initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_autoinit | input | 1 | Mode strap: 1 resets the detection field to idle with an automatic initialization, 0 resets it to offline |
| addr | input | ADDR_W | Register bus address |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte write enables, bit n for byte n |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| rdata | output | 32 | Read data for `addr`, combinational |
| phy_offline | output | 1 | Holds the PHY offline |
| gen1_limit | output | 1 | Caps negotiation at first-generation rate |
| init_active | output | 1 | High while the initialization stand-in runs |

## Verification
The properties assume that `strap_autoinit` only changes while `rst` is high. They also assume that every write lasts one cycle with `wr_en` high, and that `addr` is valid on every cycle, because read-back properties are checked only when the bus points at `REG_ADDR`. The stimulus sets the strap inside the reset task and drives all bus inputs on the falling edge. Between writes it leaves `addr` at `REG_ADDR`, so the field-to-output relations are observed on almost every cycle. The initialization-length property counts cycles since the last launch, so it needs launches to come only from bus writes or from reset, and the bench keeps to that.

// File: rtl/sata_lnk_pkg.sv
package sata_lnk_pkg;

    localparam logic [3:0] DET_IDLE    = 4'h0;
    localparam logic [3:0] DET_HRST    = 4'h1;
    localparam logic [3:0] DET_OFFLINE = 4'h4;
    localparam logic [3:0] SPD_GEN1    = 4'h1;

    typedef struct packed {
        logic [3:0] spd;
        logic [3:0] det;
    } lnk_fields_t;

    // A launch comes only from the two recognised detection-field changes.
    function automatic logic det_launch(input logic [3:0] old_v, input logic [3:0] new_v);
        return ((old_v == DET_IDLE)    && (new_v == DET_HRST)) ||
               ((old_v == DET_OFFLINE) && (new_v == DET_IDLE));
    endfunction

    // Read image: reserved bits and the unimplemented power field are zero.
    function automatic logic [31:0] read_image(input lnk_fields_t f);
        return {20'h0, 4'h0, f.spd, f.det};
    endfunction

endpackage

// File: rtl/lnk_field_store.sv
module lnk_field_store
    import sata_lnk_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_autoinit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        be,
    input  logic              wr_en,
    output logic              upd,
    output lnk_fields_t       nxt,
    output lnk_fields_t       cur,
    output logic              sel
);
    localparam logic [ADDR_W-1:0] REG_SEL = ADDR_W'(REG_ADDR);

    assign sel = (addr == REG_SEL);
    // Only byte 0 carries live state; byte 1 (power field) is dropped.
    assign upd = wr_en && sel && be[0];
    assign nxt = lnk_fields_t'(wdata[7:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.spd <= 4'h0;
            cur.det <= strap_autoinit ? DET_IDLE : DET_OFFLINE;
        end else if (upd) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/lnk_det_watch.sv
module lnk_det_watch
    import sata_lnk_pkg::*;
(
    input  logic       upd,
    input  logic [3:0] old_det,
    input  logic [3:0] new_det,
    output logic       kick
);
    always_comb begin
        kick = upd && det_launch(old_det, new_det);
    end
endmodule

// File: rtl/lnk_init_timer.sv
module lnk_init_timer #(
    parameter int unsigned INIT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic strap_autoinit,
    input  logic kick,
    output logic active
);
    localparam int unsigned CW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(INIT_CYCLES);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= strap_autoinit ? LOAD : '0;
        end else if (kick) begin
            remain <= LOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign active = (remain != '0);
endmodule

// File: rtl/sata_link_ctrl.sv
module sata_link_ctrl
    import sata_lnk_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned REG_ADDR    = 8,
    parameter int unsigned INIT_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_autoinit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        be,
    input  logic              wr_en,
    output logic [31:0]       rdata,
    output logic              phy_offline,
    output logic              gen1_limit,
    output logic              init_active
);
    lnk_fields_t f_cur, f_nxt;
    logic        f_upd, f_sel, init_kick;

    lnk_field_store #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_store (
        .clk(clk), .rst(rst), .strap_autoinit(strap_autoinit),
        .addr(addr), .wdata(wdata), .be(be), .wr_en(wr_en),
        .upd(f_upd), .nxt(f_nxt), .cur(f_cur), .sel(f_sel)
    );

    lnk_det_watch u_watch (
        .upd(f_upd), .old_det(f_cur.det), .new_det(f_nxt.det), .kick(init_kick)
    );

    lnk_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .strap_autoinit(strap_autoinit),
        .kick(init_kick), .active(init_active)
    );

    assign rdata       = f_sel ? read_image(f_cur) : 32'h0;
    assign phy_offline = (f_cur.det == DET_OFFLINE);
    assign gen1_limit  = (f_cur.spd == SPD_GEN1);
endmodule

// File: rtl/sata_link_ctrl_chk.sv
module sata_link_ctrl_chk #(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned REG_ADDR    = 8,
    parameter int unsigned INIT_CYCLES = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        be,
    input logic              wr_en,
    input logic [31:0]       rdata,
    input logic              phy_offline,
    input logic              gen1_limit,
    input logic              init_active,
    input logic              init_kick
);
    localparam logic [ADDR_W-1:0] REG_SEL = ADDR_W'(REG_ADDR);
    localparam int unsigned RW = $clog2(INIT_CYCLES + 1) + 1;

    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || init_kick || !init_active) run <= '0;
        else                                  run <= run + 1'b1;
    end

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        rdata[31:12] == 20'h0);
    p_other_addr_r1: assert property (@(posedge clk) disable iff (rst)
        (addr != REG_SEL) |-> (rdata == 32'h0));
    p_pm_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rdata[11:8] == 4'h0);
    p_gen1_r3: assert property (@(posedge clk) disable iff (rst)
        (addr == REG_SEL) |-> (gen1_limit == (rdata[7:4] == 4'h1)));
    p_offline_r5: assert property (@(posedge clk) disable iff (rst)
        (addr == REG_SEL) |-> (phy_offline == (rdata[3:0] == 4'h4)));
    p_start_r7: assert property (@(posedge clk) disable iff (rst)
        init_kick |=> init_active);
    p_run_len_r9: assert property (@(posedge clk) disable iff (rst)
        init_active |-> (run < RW'(INIT_CYCLES)));
    p_lane0_r11: assert property (@(posedge clk) disable iff (rst)
        init_kick |-> (wr_en && be[0] && addr == REG_SEL));
endmodule

bind sata_link_ctrl sata_link_ctrl_chk #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .INIT_CYCLES(INIT_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .be(be), .wr_en(wr_en),
    .rdata(rdata), .phy_offline(phy_offline), .gen1_limit(gen1_limit),
    .init_active(init_active), .init_kick(init_kick)
);

// File: tb/test_sata_link_ctrl.sv
module test_sata_link_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int REG_ADDR = 8;
    localparam int NCYC = 6;
    localparam logic [ADDR_W-1:0] RA = ADDR_W'(REG_ADDR);

    // {be, wdata, expected read[11:0], expected offline, expected gen1}
    localparam int NV = 7;
    localparam logic [49:0] VEC [NV] = '{
        {4'b0001, 32'hFFFF_F014, 12'h014, 1'b1, 1'b1},
        {4'b1110, 32'h0000_0000, 12'h014, 1'b1, 1'b1},
        {4'b1111, 32'h0000_0107, 12'h007, 1'b0, 1'b0},
        {4'b1111, 32'h0000_0024, 12'h024, 1'b1, 1'b0},
        {4'b1111, 32'h0000_0001, 12'h001, 1'b0, 1'b0},
        {4'b1111, 32'h0000_0011, 12'h011, 1'b0, 1'b1},
        {4'b1111, 32'h0000_0004, 12'h004, 1'b1, 1'b0}
    };

    logic clk = 1'b0, rst = 1'b1, strap = 1'b0, wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = RA;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic phy_offline, gen1_limit, init_active;
    int nchk = 0, nbad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sata_link_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .INIT_CYCLES(NCYC)) i_sata_link_ctrl (
        .clk(clk), .rst(rst), .strap_autoinit(strap), .addr(addr), .wdata(wdata),
        .be(be), .wr_en(wr_en), .rdata(rdata), .phy_offline(phy_offline),
        .gen1_limit(gen1_limit), .init_active(init_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        strap = s; rst = 1'b1; wr_en = 1'b0; addr = RA;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] b);
        addr = a; wdata = d; be = b; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; addr = RA;
    endtask

    task automatic high_len(output int n);
        n = 0;
        while (init_active && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        nchk++; nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        // R4: offline-mode reset
        do_reset(1'b0);
        check("R4 read", rdata, 32'h4);
        check("R4 offline", phy_offline, 1);
        repeat (3) @(negedge clk);
        check("R4 no init", init_active, 0);

        // table walk: no vector launches an initialization (R2 R3 R5 R7 R10 R11)
        for (int i = 0; i < NV; i++) begin
            wr(RA, VEC[i][45:14], VEC[i][49:46]);
            check($sformatf("R3/R10 v%0d read", i), rdata, {20'h0, VEC[i][13:2]});
            check($sformatf("R5 v%0d offline", i), phy_offline, VEC[i][1]);
            check($sformatf("R3 v%0d gen1", i), gen1_limit, VEC[i][0]);
            check($sformatf("R10 v%0d no init", i), init_active, 0);
        end

        // R1: other address
        wr(RA + 1, 32'h0000_0010, 4'hF);
        addr = RA + 1;
        @(negedge clk);
        check("R1 other read", rdata, 0);
        addr = RA;
        @(negedge clk);
        check("R1 write ignored", rdata, 32'h4);
        check("R1 no init", init_active, 0);

        // R11: byte 0 off, 0100->0000 would launch
        wr(RA, 32'h0, 4'b1110);
        check("R11 no update", rdata, 32'h4);
        check("R11 no init", init_active, 0);

        // R6: 0100 -> 0000
        wr(RA, 32'h0, 4'h1);
        check("R6 offline off", phy_offline, 0);
        high_len(n);
        check("R6 length", n, NCYC);

        // R7 and R8: 0000 -> 0001 then 0000 at once
        wr(RA, 32'h1, 4'h1);
        check("R7 active", init_active, 1);
        wr(RA, 32'h0, 4'h1);
        high_len(n);
        check("R8 not cut short", n, NCYC - 1);

        // R9: restart during run
        wr(RA, 32'h1, 4'h1);
        wr(RA, 32'h0, 4'h1);
        repeat (2) @(negedge clk);
        wr(RA, 32'h1, 4'h1);
        high_len(n);
        check("R9 restart length", n, NCYC);

        // R7: 0001 rewritten while 0001 is not a trigger
        wr(RA, 32'h1, 4'h1);
        check("R7 repeat no init", init_active, 0);

        // R4: auto-init reset
        do_reset(1'b1);
        check("R4 auto read", rdata, 0);
        check("R4 auto online", phy_offline, 0);
        high_len(n);
        check("R4 auto length", n, NCYC);

        finish_run();
    end
endmodule